// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the host side of a four-channel DMA controller. A host reaches it through a narrow I/O port: a 4-bit port address, separate write and read strobes, and 8-bit write and read data. For each channel it holds a 16-bit transfer address, a 16-bit transfer count, a mask bit and a 6-bit mode field. It presents all of these to the transfer engine as flat vectors. Channel n occupies bits [16n+15:16n] of the address and count vectors, bit n of the mask vector and bits [6n+5:6n] of the mode vector.

Each 16-bit value passes through one 8-bit port, one byte per access. A single byte-pointer bit selects the byte. All eight address and count ports share that bit, and every access to any of them flips it. The host first writes the clear-pointer port to put the pointer in a known state. It then moves low byte, then high byte. The count holds the number of transfers minus one. The register file stores the count exactly as written and does not interpret it.

Ports 8 to 15 carry the control writes: single-channel mask, mode, clear-pointer, master clear, clear-all-masks and load-all-masks. Ports 8 and 9 are reserved for command and request functions that live elsewhere. Writes to them have no effect here.

Top module: `dma_regfile`

## Requirements
- R1: After reset, all four mask bits are 1, every mode field is 0, every address and count is 0x0000 and the byte pointer selects the low byte.
- R2: A write to port 2n (n = 0..3) loads one byte of channel n's address. With the pointer low it loads bits 7:0, with the pointer high bits 15:8, and the other byte is kept. The new value appears on the address output the cycle after the write.
- R3: A write to port 2n+1 loads channel n's count the same way. The value is stored raw, so 0x0000 (one transfer) and 0xFFFF (65536 transfers) both read back unchanged on the count output.
- R4: A read of ports 0..7 returns, combinationally while the read strobe is high, the low byte when the pointer is low and the high byte when it is high. A read of ports 8..15 returns 0x00. The read data is 0x00 whenever the read strobe is low.
- R5: Every read or write of ports 0..7 toggles the one shared pointer. A low-byte access to one port is therefore followed by a high-byte access to whichever port comes next.
- R6: A write to port 12 forces the pointer to the low byte, whatever the data value.
- R7: A write to port 10 sets the mask bit of the channel in data bits 1:0 to data bit 2 (1 masks, 0 unmasks). The other mask bits and the other data bits have no effect.
- R8: A write to port 11 stores data bits 7:2 as the mode of the channel in data bits 1:0. For example, 0x46 gives channel 2 mode 0x11, 0x4B gives channel 3 mode 0x12 and 0xC1 gives channel 1 mode 0x30. The other channels keep their modes.
- R9: A write to port 13 (master clear) sets all masks to 1, clears all modes, addresses and counts, and returns the pointer to the low byte.
- R10: A write to port 14 clears all four mask bits. A write to port 15 loads mask bit n from data bit n (n = 0..3).
- R11: Writes to ports 8 and 9 change no output and leave the pointer where it was. With no write strobe, no stored value changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Port address |
| io_wr | input | 1 | Write strobe, one access per cycle high |
| io_rd | input | 1 | Read strobe, one access per cycle high |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| ch_mask | output | 4 | Per-channel mask, 1 = disabled |
| ch_mode | output | 24 | Per-channel mode, 6 bits per channel |
| ch_addr | output | 64 | Per-channel address, 16 bits per channel |
| ch_count | output | 64 | Per-channel count (transfers minus one) |

## Verification
The bench aims at the pointer that all channels share. A design that kept one pointer per channel, or reset it on a port change, would put a byte meant for one channel's high half into another channel's low half. It also checks that reads advance the pointer and that port 12 and master clear reset it. Without this, the second byte of a pair would land in the wrong half. The bench writes the extreme counts 0x0000 and 0xFFFF, which catches any design that adjusts the count on the way in. It sends mask and mode writes with junk in the unused data bits and writes to the reserved ports. These catch a design that decodes too many bits or lets a reserved port disturb the state or the pointer.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;

  typedef enum logic [3:0] {
    PORT_CMD      = 4'd8,
    PORT_REQ      = 4'd9,
    PORT_MASK_ONE = 4'd10,
    PORT_MODE     = 4'd11,
    PORT_CLR_PTR  = 4'd12,
    PORT_MCLR     = 4'd13,
    PORT_CLR_MASK = 4'd14,
    PORT_ALL_MASK = 4'd15
  } ctl_port_e;

  // Replace one byte of a 16-bit word; hi selects bits 15:8.
  function automatic logic [15:0] put_byte(input logic [15:0] word,
                                           input logic [7:0]  b,
                                           input logic        hi);
    logic [15:0] r;
    r = word;
    if (hi) r[15:8] = b;
    else    r[7:0]  = b;
    return r;
  endfunction

  // Pick one byte of a 16-bit word; hi selects bits 15:8.
  function automatic logic [7:0] get_byte(input logic [15:0] word,
                                          input logic        hi);
    return hi ? word[15:8] : word[7:0];
  endfunction

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regfile_pkg::*;
#(
  parameter int AW  = 4,
  parameter int CHW = 2
) (
  input  logic [AW-1:0]  io_addr,
  input  logic           io_wr,
  input  logic           io_rd,
  output logic           acc_word,
  output logic           wr_word,
  output logic           rd_word,
  output logic [CHW-1:0] acc_ch,
  output logic           acc_is_cnt,
  output logic           wr_mask1,
  output logic           wr_mode,
  output logic           wr_clrptr,
  output logic           wr_mclr,
  output logic           wr_clrmask,
  output logic           wr_allmask
);
  logic in_word_space;

  always_comb begin
    in_word_space = (io_addr[AW-1] == 1'b0);
    wr_word       = io_wr && in_word_space;
    rd_word       = io_rd && !io_wr && in_word_space;
    acc_word      = wr_word || rd_word;
    acc_ch        = io_addr[CHW:1];
    acc_is_cnt    = io_addr[0];
    wr_mask1      = io_wr && (io_addr == PORT_MASK_ONE);
    wr_mode       = io_wr && (io_addr == PORT_MODE);
    wr_clrptr     = io_wr && (io_addr == PORT_CLR_PTR);
    wr_mclr       = io_wr && (io_addr == PORT_MCLR);
    wr_clrmask    = io_wr && (io_addr == PORT_CLR_MASK);
    wr_allmask    = io_wr && (io_addr == PORT_ALL_MASK);
  end
endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_word,
  input  logic wr_clrptr,
  input  logic wr_mclr,
  output logic ptr_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    ptr_hi <= 1'b0;
    else if (wr_clrptr || wr_mclr) ptr_hi <= 1'b0;
    else if (acc_word)             ptr_hi <= ~ptr_hi;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regfile_pkg::*;
#(
  parameter int CH  = 0,
  parameter int CHW = 2,
  parameter int DW  = 8,
  parameter int WW  = 16,
  parameter int MW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  io_wdata,
  input  logic           wr_word,
  input  logic [CHW-1:0] acc_ch,
  input  logic           acc_is_cnt,
  input  logic           ptr_hi,
  input  logic           wr_mask1,
  input  logic           wr_mode,
  input  logic           wr_mclr,
  input  logic           wr_clrmask,
  input  logic           wr_allmask,
  output logic [WW-1:0]  addr_q,
  output logic [WW-1:0]  cnt_q,
  output logic           mask_q,
  output logic [MW-1:0]  mode_q
);
  logic hit_word, hit_sel;

  assign hit_word = wr_word && (acc_ch == CHW'(CH));
  assign hit_sel  = (io_wdata[CHW-1:0] == CHW'(CH));

  always_ff @(posedge clk) begin
    if (!rst_n || wr_mclr) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (hit_word) begin
      if (acc_is_cnt) cnt_q  <= put_byte(cnt_q, io_wdata, ptr_hi);
      else            addr_q <= put_byte(addr_q, io_wdata, ptr_hi);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_mclr)        mask_q <= 1'b1;
    else if (wr_clrmask)          mask_q <= 1'b0;
    else if (wr_allmask)          mask_q <= io_wdata[CH];
    else if (wr_mask1 && hit_sel) mask_q <= io_wdata[CHW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_mclr)       mode_q <= '0;
    else if (wr_mode && hit_sel) mode_q <= io_wdata[DW-1:DW-MW];
  end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_regfile_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 4,
  parameter int DW  = 8,
  parameter int WW  = 16,
  parameter int MW  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  output logic [NCH-1:0]    ch_mask,
  output logic [NCH*MW-1:0] ch_mode,
  output logic [NCH*WW-1:0] ch_addr,
  output logic [NCH*WW-1:0] ch_count
);
  localparam int CHW = $clog2(NCH);

  logic           acc_word, wr_word, rd_word, acc_is_cnt, ptr_hi;
  logic [CHW-1:0] acc_ch;
  logic           wr_mask1, wr_mode, wr_clrptr, wr_mclr, wr_clrmask, wr_allmask;
  logic [WW-1:0]  addr_arr [NCH];
  logic [WW-1:0]  cnt_arr  [NCH];

  dma_port_decode #(.AW(AW), .CHW(CHW)) u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .acc_word(acc_word), .wr_word(wr_word), .rd_word(rd_word),
    .acc_ch(acc_ch), .acc_is_cnt(acc_is_cnt),
    .wr_mask1(wr_mask1), .wr_mode(wr_mode), .wr_clrptr(wr_clrptr),
    .wr_mclr(wr_mclr), .wr_clrmask(wr_clrmask), .wr_allmask(wr_allmask)
  );

  dma_byte_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .acc_word(acc_word),
    .wr_clrptr(wr_clrptr), .wr_mclr(wr_mclr), .ptr_hi(ptr_hi)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan_regs #(.CH(g), .CHW(CHW), .DW(DW), .WW(WW), .MW(MW)) u_ch (
      .clk(clk), .rst_n(rst_n), .io_wdata(io_wdata),
      .wr_word(wr_word), .acc_ch(acc_ch), .acc_is_cnt(acc_is_cnt),
      .ptr_hi(ptr_hi), .wr_mask1(wr_mask1), .wr_mode(wr_mode),
      .wr_mclr(wr_mclr), .wr_clrmask(wr_clrmask), .wr_allmask(wr_allmask),
      .addr_q(addr_arr[g]), .cnt_q(cnt_arr[g]),
      .mask_q(ch_mask[g]), .mode_q(ch_mode[g*MW +: MW])
    );
    assign ch_addr [g*WW +: WW] = addr_arr[g];
    assign ch_count[g*WW +: WW] = cnt_arr[g];
  end

  always_comb begin
    io_rdata = '0;
    if (rd_word)
      io_rdata = get_byte(acc_is_cnt ? cnt_arr[acc_ch] : addr_arr[acc_ch], ptr_hi);
  end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int WW  = 16,
  parameter int MW  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic              io_rd,
  input logic [DW-1:0]     io_wdata,
  input logic [DW-1:0]     io_rdata,
  input logic [NCH-1:0]    ch_mask,
  input logic [NCH*MW-1:0] ch_mode,
  input logic [NCH*WW-1:0] ch_addr,
  input logic [NCH*WW-1:0] ch_count,
  input logic              acc_word,
  input logic              ptr_hi,
  input logic              wr_clrptr,
  input logic              wr_mclr,
  input logic              wr_clrmask,
  input logic              wr_allmask
);
  // R5
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_word && !wr_clrptr && !wr_mclr |=> ptr_hi != $past(ptr_hi));

  // R6
  clr_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clrptr |=> !ptr_hi);

  // R9
  master_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> (&ch_mask) && (ch_mode == '0) && (ch_addr == '0) && (ch_count == '0) && !ptr_hi);

  // R10
  clear_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clrmask |=> ch_mask == '0);

  // R10
  all_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_allmask |=> ch_mask == $past(io_wdata[NCH-1:0]));

  // R11
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(ch_mask) && $stable(ch_mode) && $stable(ch_addr) && $stable(ch_count));

  // R4
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == '0);
endmodule

bind dma_regfile dma_regfile_chk #(.NCH(NCH), .DW(DW), .WW(WW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .ch_mask(ch_mask),
  .ch_mode(ch_mode), .ch_addr(ch_addr), .ch_count(ch_count),
  .acc_word(acc_word), .ptr_hi(ptr_hi), .wr_clrptr(wr_clrptr),
  .wr_mclr(wr_mclr), .wr_clrmask(wr_clrmask), .wr_allmask(wr_allmask)
);

// File: tb/dma_regfile_test.sv
module dma_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [3:0]  ch_mask;
  logic [23:0] ch_mode;
  logic [63:0] ch_addr;
  logic [63:0] ch_count;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  dma_regfile uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .ch_mask(ch_mask),
    .ch_mode(ch_mode), .ch_addr(ch_addr), .ch_count(ch_count)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] q);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 q = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  // {is_read, port, data or expected byte}
  localparam int NV = 17;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 4'hC, 8'h00},
    {1'b0, 4'h0, 8'h34}, {1'b0, 4'h0, 8'h12},
    {1'b0, 4'h3, 8'hFF}, {1'b0, 4'h3, 8'hFF},
    {1'b0, 4'h4, 8'hCD}, {1'b0, 4'h4, 8'hAB},
    {1'b0, 4'h7, 8'h00}, {1'b0, 4'h7, 8'h00},
    {1'b1, 4'h0, 8'h34}, {1'b1, 4'h0, 8'h12},
    {1'b1, 4'h3, 8'hFF}, {1'b1, 4'h3, 8'hFF},
    {1'b1, 4'h4, 8'hCD}, {1'b1, 4'h4, 8'hAB},
    {1'b1, 4'h7, 8'h00}, {1'b1, 4'h7, 8'h00}
  };

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 mask", {60'd0, ch_mask}, 64'hF);
    chk("R1 mode", {40'd0, ch_mode}, 64'h0);
    chk("R1 addr", ch_addr, 64'h0);
    chk("R1 count", ch_count, 64'h0);
    chk("R4 idle rdata", {56'd0, io_rdata}, 64'h0);

    // R4 vector walk: byte reads low then high
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][12]) begin
        rd(VEC[i][11:8], q);
        chk("R4 readback", {56'd0, q}, {56'd0, VEC[i][7:0]});
      end else begin
        wr(VEC[i][11:8], VEC[i][7:0]);
      end
    end
    chk("R2 ch0 addr", {48'd0, ch_addr[15:0]}, 64'h1234);
    chk("R2 ch2 addr", {48'd0, ch_addr[47:32]}, 64'hABCD);
    chk("R3 ch1 count max", {48'd0, ch_count[31:16]}, 64'hFFFF);
    chk("R3 ch3 count min", {48'd0, ch_count[63:48]}, 64'h0000);
    rd(4'hA, q);
    chk("R4 control port read", {56'd0, q}, 64'h0);

    // R5 shared pointer across ports
    wr(4'h0, 8'h55);
    wr(4'h1, 8'h66);
    chk("R5 ch0 addr low", {48'd0, ch_addr[15:0]}, 64'h1255);
    chk("R5 ch0 count high", {48'd0, ch_count[15:0]}, 64'h6600);

    // R6 clear pointer with nonzero data
    wr(4'h0, 8'h77);
    wr(4'hC, 8'hA5);
    wr(4'h0, 8'h88);
    chk("R6 after clear", {48'd0, ch_addr[15:0]}, 64'h1288);
    wr(4'hC, 8'h00);

    // R7 single mask
    wr(4'hA, 8'h02);
    chk("R7 unmask ch2", {60'd0, ch_mask}, 64'hB);
    wr(4'hA, 8'h00);
    wr(4'hA, 8'h04);
    chk("R7 remask ch0", {60'd0, ch_mask}, 64'hB);
    wr(4'hA, 8'hF9);
    chk("R7 junk bits", {60'd0, ch_mask}, 64'h9);

    // R8 mode
    wr(4'hB, 8'h46);
    wr(4'hB, 8'h4B);
    wr(4'hB, 8'hC1);
    chk("R8 modes", {40'd0, ch_mode}, {40'd0, 6'h12, 6'h11, 6'h30, 6'h00});

    // R10 clear mask and load all masks
    wr(4'hF, 8'h05);
    chk("R10 all mask", {60'd0, ch_mask}, 64'h5);
    wr(4'hE, 8'hFF);
    chk("R10 clear mask", {60'd0, ch_mask}, 64'h0);
    wr(4'hF, 8'h3A);
    chk("R10 all mask upper ignored", {60'd0, ch_mask}, 64'hA);

    // R11 reserved ports: no state change, pointer untouched
    wr(4'h8, 8'hFF);
    wr(4'h9, 8'hFF);
    chk("R11 mask kept", {60'd0, ch_mask}, 64'hA);
    chk("R11 mode kept", {40'd0, ch_mode}, {40'd0, 6'h12, 6'h11, 6'h30, 6'h00});
    wr(4'h0, 8'h99);
    chk("R11 pointer kept low", {48'd0, ch_addr[15:0]}, 64'h1299);

    // R9 master clear with pointer high
    wr(4'hD, 8'h00);
    chk("R9 mask", {60'd0, ch_mask}, 64'hF);
    chk("R9 mode", {40'd0, ch_mode}, 64'h0);
    chk("R9 addr", ch_addr, 64'h0);
    chk("R9 count", ch_count, 64'h0);
    wr(4'h2, 8'hAA);
    chk("R9 pointer low", {48'd0, ch_addr[31:16]}, 64'h00AA);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule